// File: doc/BRIEF.md
# Hyperframe Alignment and Pattern Checker

This receive-side checker watches a parallel stream of data beats with a per-byte control lane. It searches the stream for the hyperframe synchronization word and confirms alignment when a second sync word arrives exactly one hyperframe later. While aligned, it keeps checking that sync words keep arriving in their expected slot. It drops alignment after several slots in a row have no sync word.

Once aligned, every beat that is not a sync word is compared against an incrementing reference value. The reference restarts at zero on each sync word. Mismatches are counted in a saturating counter that also drives a sticky error flag. A one-cycle stop pulse marks each sync word that is confirmed in its slot, so that a latency measurement can be taken against the transmitter's start pulse.

The hyperframe length in beats depends on a run-time rate code and on a shortening parameter. Both must be set to the same values as in the matching generator.

Top module: `hf_sync_checker`

## Requirements
- R1: While `rst_n` is low (asynchronously), `hf_locked`, `err_sticky`, `stop_pulse` are 0 and `err_count` is 0.
- R2: A beat is a sync word only when `rx_ctrl` equals 1 (bit 0 set, every other bit clear) and `rx_data[7:0]` equals `SYNC_CHAR` (default 8'hBC). Any other beat is data.
- R3: The hyperframe length is `HF_UNIT*(r+1)/D` beats. Here r is `rate_sel`, with codes above 7 treated as 7, and D is 1, 4 or 64 for `SIM_MODE` 0, 1 or 2.
- R4: From search, a sync word starts an alignment attempt. A second sync word exactly one hyperframe later raises `hf_locked` from the next beat. During an attempt, a sync word at any other spacing restarts the attempt from that word, and a missing word in the expected slot returns to search.
- R5: While locked, a slot without a sync word counts as a miss and a sync word in the slot clears the count. On the third consecutive miss, `hf_locked` falls in the next beat.
- R6: Only while `hf_locked` is high is each non-sync beat compared. The beat must have `rx_ctrl` all zero and `rx_data` equal to the reference. While unlocked, no beat changes `err_count`.
- R7: The reference is 0 on the first beat after any sync word, including a sync word outside its slot, and increases by one on every following beat.
- R8: Each mismatching beat adds one to `err_count`, visible from the next beat. The count stops at 31 and never wraps.
- R9: `err_sticky` is high exactly when `err_count` is nonzero. Only reset clears it.
- R10: `stop_pulse` is high for one beat following each sync word seen in its expected slot while an attempt or lock is active. It stays low in search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive beat clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | 4 | Rate code selecting the hyperframe length |
| rx_data | input | DATA_WIDTH | Received data beat |
| rx_ctrl | input | CTRL_WIDTH | Received per-byte control flags |
| hf_locked | output | 1 | Hyperframe alignment achieved |
| err_sticky | output | 1 | Latched indication that a mismatch occurred |
| err_count | output | ERR_W | Saturating count of mismatching beats |
| stop_pulse | output | 1 | One-beat marker of a confirmed hyperframe boundary |

## Verification
Some properties are checked by assertions on every cycle:
- The error counter only grows in steps of one, holds at its ceiling, and never moves while unlocked.
- The sticky flag always agrees with a nonzero count.
- Lock can only be entered from an alignment attempt.
- Lock can only be lost on an empty slot.
- A stop pulse never follows a search-state beat.

Other behaviour only shows up in the bench scenarios:
- The exact slot spacing for each rate code and the clamping of large codes.
- The restart of an attempt on a misplaced word.
- The reference reload after a mid-frame sync word.
- The rejection of near-miss sync words.
- The tolerance of two missed slots before loss.

// File: rtl/hfc_pkg.sv
package hfc_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_TRY    = 2'd1,
        ST_LOCK   = 2'd2
    } align_st_e;

    // Largest rate code honoured; larger codes are clamped to it.
    localparam int MAX_RATE_CODE = 7;

    // Right shift that shortens the hyperframe in simulation modes.
    function automatic int sim_shift(input int mode);
        if (mode == 2) return 6;
        if (mode == 1) return 2;
        return 0;
    endfunction

endpackage

// File: rtl/hfc_frame_len.sv
module hfc_frame_len
    import hfc_pkg::*;
#(
    parameter int HF_UNIT  = 256,
    parameter int SIM_MODE = 0,
    parameter int POS_W    = 12
) (
    input  logic [3:0]       rate_sel,
    output logic [POS_W-1:0] hf_len
);
    localparam int SHIFT = sim_shift(SIM_MODE);

    logic [POS_W-1:0] factor;
    logic [POS_W-1:0] scaled;

    always_comb begin
        if (rate_sel > 4'(MAX_RATE_CODE)) begin
            factor = POS_W'(MAX_RATE_CODE + 1);
        end else begin
            factor = POS_W'(rate_sel) + POS_W'(1);
        end
        scaled = POS_W'(HF_UNIT) * factor;
        hf_len = scaled >> SHIFT;
    end
endmodule

// File: rtl/hfc_sync_detect.sv
module hfc_sync_detect #(
    parameter int          DATA_WIDTH = 64,
    parameter int          CTRL_WIDTH = 8,
    parameter logic [7:0]  SYNC_CHAR  = 8'hBC
) (
    input  logic [DATA_WIDTH-1:0] rx_data,
    input  logic [CTRL_WIDTH-1:0] rx_ctrl,
    output logic                  is_sync
);
    // Only the lowest byte lane carries the control character.
    localparam logic [CTRL_WIDTH-1:0] SYNC_CTRL = CTRL_WIDTH'(1);

    always_comb begin
        is_sync = (rx_ctrl == SYNC_CTRL) && (rx_data[7:0] == SYNC_CHAR);
    end
endmodule

// File: rtl/hfc_align_fsm.sv
module hfc_align_fsm
    import hfc_pkg::*;
#(
    parameter int POS_W      = 12,
    parameter int MISS_LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_sync,
    input  logic [POS_W-1:0] hf_len,
    output logic             locked,
    output logic             stop_pulse
);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);

    typedef struct packed {
        align_st_e         st;
        logic [POS_W-1:0]  pos;
        logic [MISS_W-1:0] miss;
        logic              stop;
    } fsm_t;

    fsm_t q, d;
    logic             slot;
    logic [POS_W-1:0] pos_next;

    always_comb begin
        d        = q;
        slot     = (q.pos == '0);
        pos_next = (q.pos >= hf_len - POS_W'(1)) ? '0 : q.pos + POS_W'(1);
        d.pos    = pos_next;
        d.stop   = is_sync && slot && (q.st != ST_SEARCH);
        case (q.st)
            ST_SEARCH: begin
                d.miss = '0;
                if (is_sync) d.st  = ST_TRY;
                else         d.pos = '0;
            end
            ST_TRY: begin
                if (slot) begin
                    if (is_sync) begin
                        d.st = ST_LOCK;
                    end else begin
                        d.st  = ST_SEARCH;
                        d.pos = '0;
                    end
                end else if (is_sync) begin
                    d.pos = POS_W'(1);
                end
            end
            ST_LOCK: begin
                if (slot) begin
                    if (is_sync) begin
                        d.miss = '0;
                    end else if (q.miss == MISS_W'(MISS_LIMIT - 1)) begin
                        d.st   = ST_SEARCH;
                        d.pos  = '0;
                        d.miss = '0;
                    end else begin
                        d.miss = q.miss + MISS_W'(1);
                    end
                end
            end
            default: begin
                d.st   = ST_SEARCH;
                d.pos  = '0;
                d.miss = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ST_SEARCH, '0, '0, 1'b0};
        else        q <= d;
    end

    assign locked     = (q.st == ST_LOCK);
    assign stop_pulse = q.stop;

    // R4: lock is only entered from an alignment attempt
    a_r4_lock_via_try: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(q.st) == ST_TRY);

    // R5: lock is only lost on an expected slot that lacked a sync word
    a_r5_drop_on_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> ($past(q.pos) == '0) && !$past(is_sync));

    // R10: no boundary marker after a beat spent searching
    a_r10_stop_not_from_search: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> $past(q.st) != ST_SEARCH);
endmodule

// File: rtl/hfc_pattern_check.sv
module hfc_pattern_check #(
    parameter int DATA_WIDTH = 64,
    parameter int CTRL_WIDTH = 8,
    parameter int ERR_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  is_sync,
    input  logic                  locked,
    input  logic [DATA_WIDTH-1:0] rx_data,
    input  logic [CTRL_WIDTH-1:0] rx_ctrl,
    output logic [ERR_W-1:0]      err_count,
    output logic                  err_sticky
);
    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [DATA_WIDTH-1:0] expv;
        logic [ERR_W-1:0]      cnt;
        logic                  sticky;
    } chk_t;

    chk_t q, d;
    logic mismatch;

    always_comb begin
        d        = q;
        mismatch = locked && !is_sync &&
                   ((rx_data != q.expv) || (rx_ctrl != '0));
        d.expv   = is_sync ? '0 : q.expv + DATA_WIDTH'(1);
        if (mismatch && (q.cnt != CNT_MAX)) d.cnt = q.cnt + ERR_W'(1);
        d.sticky = q.sticky | mismatch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign err_count  = q.cnt;
    assign err_sticky = q.sticky;

    // R8: the count moves by at most one per beat
    a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == $past(err_count)) || (err_count == $past(err_count) + ERR_W'(1)));

    // R8: the count holds at its ceiling
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == CNT_MAX) |=> (err_count == CNT_MAX));

    // R9: the sticky flag tracks a nonzero count
    a_r9_sticky_matches: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky == (err_count != '0));

    // R6: no counting while alignment is absent
    a_r6_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> $stable(err_count));
endmodule

// File: rtl/hf_sync_checker.sv
module hf_sync_checker
    import hfc_pkg::*;
#(
    parameter int         DATA_WIDTH = 64,
    parameter int         CTRL_WIDTH = 8,
    parameter int         SIM_MODE   = 0,
    parameter int         HF_UNIT    = 256,
    parameter logic [7:0] SYNC_CHAR  = 8'hBC,
    parameter int         MISS_LIMIT = 3,
    parameter int         ERR_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            rate_sel,
    input  logic [DATA_WIDTH-1:0] rx_data,
    input  logic [CTRL_WIDTH-1:0] rx_ctrl,
    output logic                  hf_locked,
    output logic                  err_sticky,
    output logic [ERR_W-1:0]      err_count,
    output logic                  stop_pulse
);
    localparam int POS_W = $clog2(HF_UNIT * (MAX_RATE_CODE + 1)) + 1;

    logic [POS_W-1:0] hf_len;
    logic             is_sync;

    hfc_frame_len #(
        .HF_UNIT (HF_UNIT),
        .SIM_MODE(SIM_MODE),
        .POS_W   (POS_W)
    ) u_len (
        .rate_sel(rate_sel),
        .hf_len  (hf_len)
    );

    hfc_sync_detect #(
        .DATA_WIDTH(DATA_WIDTH),
        .CTRL_WIDTH(CTRL_WIDTH),
        .SYNC_CHAR (SYNC_CHAR)
    ) u_det (
        .rx_data(rx_data),
        .rx_ctrl(rx_ctrl),
        .is_sync(is_sync)
    );

    hfc_align_fsm #(
        .POS_W     (POS_W),
        .MISS_LIMIT(MISS_LIMIT)
    ) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_sync   (is_sync),
        .hf_len    (hf_len),
        .locked    (hf_locked),
        .stop_pulse(stop_pulse)
    );

    hfc_pattern_check #(
        .DATA_WIDTH(DATA_WIDTH),
        .CTRL_WIDTH(CTRL_WIDTH),
        .ERR_W     (ERR_W)
    ) u_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_sync   (is_sync),
        .locked    (hf_locked),
        .rx_data   (rx_data),
        .rx_ctrl   (rx_ctrl),
        .err_count (err_count),
        .err_sticky(err_sticky)
    );
endmodule

// File: tb/hf_sync_checker_tb.sv
module hf_sync_checker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 64;
    localparam int CW   = 8;
    localparam int SIMM = 2;
    localparam int UNIT = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    rate_sel = 4'd0;
    logic [DW-1:0] rx_data = '0;
    logic [CW-1:0] rx_ctrl = '0;
    logic          hf_locked, err_sticky, stop_pulse;
    logic [4:0]    err_count;

    hf_sync_checker #(
        .DATA_WIDTH(DW), .CTRL_WIDTH(CW), .SIM_MODE(SIMM), .HF_UNIT(UNIT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
        .rx_data(rx_data), .rx_ctrl(rx_ctrl),
        .hf_locked(hf_locked), .err_sticky(err_sticky),
        .err_count(err_count), .stop_pulse(stop_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic       lk;
        logic       sp;
        logic [4:0] cnt;
        logic       sk;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    int stop_seen = 0;

    // reference model state (built from the requirements)
    int            m_st = 0;   // 0 search, 1 attempt, 2 locked
    int            m_pos = 0;
    int            m_miss = 0;
    int            m_cnt = 0;
    logic          m_sticky = 1'b0;
    logic [DW-1:0] m_exp = '0;

    task automatic chk(input string req, input longint act, input longint expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int frame_len(input int r);
        int rr;
        rr = (r > 7) ? 7 : r;
        return (UNIT * (rr + 1)) >> 6;
    endfunction

    // driver: one beat, reference prediction pushed into the scoreboard
    task automatic beat(input logic [DW-1:0] d, input logic [CW-1:0] c, input string tag);
        bit   det, slot, mism, nstop;
        int   len, nst, npos, nmiss;
        exp_t e;
        @(negedge clk);
        rx_data = d;
        rx_ctrl = c;
        len   = frame_len(int'(rate_sel));
        det   = (c == 8'h01) && (d[7:0] == 8'hBC);
        slot  = (m_pos == 0);
        mism  = (m_st == 2) && !det && ((d != m_exp) || (c != '0));
        nst   = m_st;
        nmiss = m_miss;
        npos  = (m_pos >= len - 1) ? 0 : m_pos + 1;
        nstop = det && slot && (m_st != 0);
        if (m_st == 0) begin
            nmiss = 0;
            if (det) nst = 1; else npos = 0;
        end else if (m_st == 1) begin
            if (slot) begin
                if (det) nst = 2;
                else begin nst = 0; npos = 0; end
            end else if (det) npos = 1;
        end else begin
            if (slot) begin
                if (det) nmiss = 0;
                else if (m_miss == 2) begin nst = 0; npos = 0; nmiss = 0; end
                else nmiss = m_miss + 1;
            end
        end
        m_exp = det ? '0 : m_exp + 1;
        if (mism && m_cnt < 31) m_cnt++;
        if (mism) m_sticky = 1'b1;
        m_st = nst; m_pos = npos; m_miss = nmiss;
        e.lk = (m_st == 2); e.sp = nstop; e.cnt = 5'(m_cnt); e.sk = m_sticky;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic sync_beat(input string tag);
        beat(DW'(8'hBC), 8'h01, tag);
    endtask

    task automatic beat_ok(input string tag);
        beat(m_exp, '0, tag);
    endtask

    task automatic good_frame(input string tag);
        int len;
        len = frame_len(int'(rate_sel));
        sync_beat(tag);
        for (int j = 0; j < len - 1; j++) beat(DW'(j), '0, tag);
    endtask

    task automatic look();
        @(posedge clk);
        #2;
    endtask

    // monitor: pops predictions as results appear
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({t, " locked"}, hf_locked, e.lk);
                chk({t, " stop"}, stop_pulse, e.sp);
                chk({t, " count"}, err_count, e.cnt);
                chk({t, " sticky"}, err_sticky, e.sk);
                if (stop_pulse) stop_seen++;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 locked", hf_locked, 0);
        chk("R1 count", err_count, 0);
        chk("R1 sticky", err_sticky, 0);
        chk("R1 stop", stop_pulse, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3/R4/R10: acquisition at rate 0 (4 beats)
        repeat (3) beat('0, '0, "R4 idle");
        stop_seen = 0;
        good_frame("R4 first");
        look();
        chk("R4 one word not enough", hf_locked, 0);
        for (int k = 0; k < 4; k++) good_frame("R6 frames");
        look();
        chk("R4 locked", hf_locked, 1);
        chk("R6 clean count", err_count, 0);
        chk("R10 stop count", stop_seen, 4);

        // R7: misplaced sync word reloads reference
        sync_beat("R7");
        beat(DW'(0), '0, "R7");
        sync_beat("R7 misplaced");
        beat(DW'(0), '0, "R7 reload");
        good_frame("R7");
        look();
        chk("R7 no cascade", err_count, 0);
        chk("R7 still locked", hf_locked, 1);

        // R8/R9: single corrupted beat
        sync_beat("R8");
        beat(DW'(0), '0, "R8");
        beat(DW'(99), '0, "R8 corrupt");
        beat(DW'(2), '0, "R8");
        good_frame("R8");
        look();
        chk("R8 one error", err_count, 1);
        chk("R9 sticky set", err_sticky, 1);

        // R5: two misses tolerated, three lose lock
        for (int k = 0; k < 8; k++) beat_ok("R5 two misses");
        sync_beat("R5 recover");
        for (int k = 0; k < 3; k++) beat_ok("R5 recover");
        look();
        chk("R5 kept lock", hf_locked, 1);
        for (int k = 0; k < 12; k++) beat_ok("R5 three misses");
        look();
        chk("R5 lost lock", hf_locked, 0);

        // R2/R6: near-miss sync words and garbage while unlocked
        for (int k = 0; k < 3; k++) begin
            beat(DW'(8'hBC), 8'h03, "R2 bad ctrl");
            repeat (3) beat('0, '0, "R2 idle");
        end
        for (int k = 0; k < 3; k++) begin
            beat(DW'(8'hBD), 8'h01, "R2 bad char");
            repeat (3) beat('0, '0, "R2 idle");
        end
        for (int k = 0; k < 4; k++) beat(DW'(64'hDEAD), 8'hFF, "R6 unlocked garbage");
        look();
        chk("R2 no lock", hf_locked, 0);
        chk("R6 no count unlocked", err_count, 1);

        // R3/R4: rate 3 (16 beats) with attempt restart
        rate_sel = 4'd3;
        sync_beat("R4 attempt");
        for (int j = 0; j < 4; j++) beat(DW'(j), '0, "R4 attempt");
        sync_beat("R4 restart");
        for (int j = 0; j < 15; j++) beat(DW'(j), '0, "R3 rate3");
        sync_beat("R3 rate3 confirm");
        look();
        chk("R3 lock at rate 3", hf_locked, 1);
        for (int k = 0; k < 48; k++) beat_ok("R5 rate3 loss");
        look();
        chk("R5 lost at rate 3", hf_locked, 0);

        // R3: code 9 clamps to 7 (32 beats)
        rate_sel = 4'd9;
        good_frame("R3 clamp");
        good_frame("R3 clamp");
        look();
        chk("R3 clamped lock", hf_locked, 1);

        // R8/R9: saturation
        for (int k = 0; k < 2; k++) begin
            sync_beat("R8 sat");
            for (int j = 0; j < 31; j++) beat(m_exp ^ DW'(64'hFF00), '0, "R8 sat");
        end
        sync_beat("R8 sat");
        look();
        chk("R8 saturated", err_count, 31);
        chk("R9 sticky held", err_sticky, 1);

        // R1/R9: reset clears everything
        rst_n = 1'b0;
        #1;
        chk("R1 relock cleared", hf_locked, 0);
        chk("R9 cleared by reset", err_sticky, 0);
        chk("R1 count cleared", err_count, 0);
        chk("R1 stop cleared", stop_pulse, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule